// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which of three oscillators drives the system clock. The choices are an internal RC oscillator, an external crystal oscillator and a PLL. Software writes a requested source into a configuration register over a small register bus. The block moves the active selection to that source only after the source's ready indication has passed through a synchronizer. A status register reports the source that is actually in use. Because that field lags the request, software can poll it to see whether a switch is still pending.

The block drives one-hot select lines to an external glitch-free clock mux. It also drives the enable lines for the external oscillator and the PLL, and the PLL reference and multiplier settings. A clock guard can be enabled. When it is on and the external oscillator reports a failure, the block makes these changes in the next cycle:
- it leaves any selection that depends on that oscillator;
- it falls back to the internal oscillator;
- it turns the external oscillator off;
- it latches a sticky flag that drives a non-maskable interrupt line.

The block also rejects writes that would remove a clock that is in use.

Register map (word addresses), used by every requirement below:
- Address 0, control: bit 0 external oscillator enable, bit 1 PLL enable, bit 2 guard enable, bit 3 flag clear (write 1; always reads 0).
- Address 1, configuration: bits 1:0 requested source, bit 4 PLL reference (1 = external oscillator, 0 = internal), bits 11:8 PLL multiplier.
- Address 2, status (read-only): bits 1:0 active source, bits 6:4 synchronized ready of internal/external/PLL, bit 8 guard flag.

Source code: 00 internal, 01 external, 10 PLL, 11 reserved.

Top module: `sysclk_sel_ctrl`

## Requirements
- R1: After reset the requested and active source are both internal (00). External enable, PLL enable, guard enable and guard flag are all 0, and only selRc is high.
- R2: Writing a request for a source whose synchronized ready is low changes the requested field at once, while the active field keeps its old value.
- R3: A pending switch completes on its own. When a ready input rises, the active field takes the requested source on the third rising clock edge after it, because of two synchronizer stages plus the state register. If the ready is already synchronized, the switch lands on the same edge as the request write. A source counts as ready only while its enable is set.
- R4: The request code 11 is reserved and behaves as a request for the internal oscillator (00). The configuration field still reads back 11.
- R5: Exactly one of selRc, selXosc and selPll is high at all times, matching the active source code.
- R6: With the guard enabled and the external oscillator enabled, a failure pulse has these effects one edge later: the active source is internal, the external enable is 0, and guardIrq is 1. This holds when the external oscillator was the system clock directly.
- R7: The same fallback applies when the PLL is the active source and uses the external oscillator as its reference.
- R8: The guard flag stays set until a control write with bit 3 set, and a control write without bit 3 leaves it set.
- R9: A control write cannot clear the external enable while that oscillator is active, or while it is the reference of an active PLL. It cannot clear the PLL enable while the PLL is active. Such a write leaves the enable at 1. A disable of a source that is not in use takes effect.
- R10: While the PLL enable is 1, writes to the PLL reference and multiplier fields are ignored. The requested-source field in the same write is still taken.
- R11: A guard failure and a software request write in the same cycle resolve in favour of the failure. The active and requested source become internal, and the flag is set.
- R12: With the guard disabled, a failure pulse changes neither the active source, the enables nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register word address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| rcReady | input | 1 | Internal oscillator ready, asynchronous |
| xoscReady | input | 1 | External oscillator ready, asynchronous |
| pllReady | input | 1 | PLL lock, asynchronous |
| xoscFail | input | 1 | External oscillator failure pulse, synchronous to clk |
| selRc | output | 1 | Mux select: internal oscillator |
| selXosc | output | 1 | Mux select: external oscillator |
| selPll | output | 1 | Mux select: PLL |
| xoscEnOut | output | 1 | External oscillator enable |
| pllEnOut | output | 1 | PLL enable |
| pllRefOut | output | 1 | PLL reference select, 1 = external |
| pllMulOut | output | MUL_W | PLL multiplier setting |
| guardIrq | output | 1 | Clock guard interrupt, non-maskable |

## Verification
The assertions take the failure input as a clean single-clock pulse generated in the clk domain. They expect the ready inputs to change only between edges, so the synchronizer is the only crossing. They also expect the bus to present one write per cycle with a stable address and data. The bench drives every input on the falling edge and keeps xoscFail high for exactly one cycle. It raises a ready line only after the matching enable is written, and holds it steady afterwards, so no assertion sees a ready glitch that the hardware would not.

// File: rtl/sysclk_sel_pkg.sv
package sysclk_sel_pkg;

  typedef enum logic [1:0] {
    SRC_RC   = 2'b00,
    SRC_XOSC = 2'b01,
    SRC_PLL  = 2'b10,
    SRC_RSVD = 2'b11
  } srcSel_e;

  localparam int N_SRC    = 3;
  localparam int IDX_RC   = 0;
  localparam int IDX_XOSC = 1;
  localparam int IDX_PLL  = 2;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_CFG  = 1;
  localparam int ADDR_STAT = 2;

  // control-word bit positions
  localparam int CB_XOSC = 0;
  localparam int CB_PLL  = 1;
  localparam int CB_GRD  = 2;
  localparam int CB_CLR  = 3;

  // configuration-word bit positions
  localparam int FB_REF = 4;
  localparam int FB_MUL = 8;

  // status-word bit positions
  localparam int SB_RDY  = 4;
  localparam int SB_FLAG = 8;

  typedef struct packed {
    logic wrCtrl;
    logic wrCfg;
  } busStrobe_t;

endpackage

// File: rtl/sysclk_sel_sync.sv
module sysclk_sel_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else if (STAGES == 1) chain <= din[b];
      else chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/sysclk_sel_busdec.sv
module sysclk_sel_busdec
  import sysclk_sel_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] ctrlWord,
  input  logic [DATA_W-1:0] cfgWord,
  input  logic [DATA_W-1:0] statWord,
  output busStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdata
);

  always_comb begin
    strobe.wrCtrl = busWr && (busAddr == ADDR_W'(ADDR_CTRL));
    strobe.wrCfg  = busWr && (busAddr == ADDR_W'(ADDR_CFG));
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(ADDR_CTRL): busRdata = ctrlWord;
      ADDR_W'(ADDR_CFG):  busRdata = cfgWord;
      ADDR_W'(ADDR_STAT): busRdata = statWord;
      default:            busRdata = '0;
    endcase
  end

endmodule

// File: rtl/sysclk_sel_core.sv
module sysclk_sel_core
  import sysclk_sel_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MUL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [N_SRC-1:0]  readySync,
  input  logic              xoscFail,
  output srcSel_e           actSel,
  output logic              xoscEn,
  output logic              pllEn,
  output logic              pllRef,
  output logic [MUL_W-1:0]  pllMul,
  output logic              guardFlag,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [DATA_W-1:0] cfgWord,
  output logic [DATA_W-1:0] statWord
);

  srcSel_e          reqSel, reqNxt, target, actNxt;
  logic             guardEn;
  logic             xoscEnNxt, pllEnNxt, guardNxt, flagNxt, refNxt;
  logic [MUL_W-1:0] mulNxt;
  logic             xoscInUse, failEvt;
  logic [N_SRC-1:0] srcOk;
  logic             unusedBits;

  assign unusedBits = ^busWdata;

  always_comb begin
    xoscInUse = (actSel == SRC_XOSC) || ((actSel == SRC_PLL) && pllRef);
    failEvt   = guardEn && xoscEn && xoscFail;

    xoscEnNxt = xoscEn;
    pllEnNxt  = pllEn;
    guardNxt  = guardEn;
    flagNxt   = guardFlag;
    reqNxt    = reqSel;
    refNxt    = pllRef;
    mulNxt    = pllMul;

    if (strobe.wrCtrl) begin
      if (busWdata[CB_XOSC] || !xoscInUse) xoscEnNxt = busWdata[CB_XOSC];
      if (busWdata[CB_PLL] || (actSel != SRC_PLL)) pllEnNxt = busWdata[CB_PLL];
      guardNxt = busWdata[CB_GRD];
      if (busWdata[CB_CLR]) flagNxt = 1'b0;
    end

    if (strobe.wrCfg) begin
      reqNxt = srcSel_e'(busWdata[1:0]);
      if (!pllEn) begin
        refNxt = busWdata[FB_REF];
        mulNxt = busWdata[FB_MUL +: MUL_W];
      end
    end

    // failure fallback overrides any software change in the same cycle
    if (failEvt) begin
      xoscEnNxt = 1'b0;
      flagNxt   = 1'b1;
      reqNxt    = SRC_RC;
    end

    target = (reqNxt == SRC_RSVD) ? SRC_RC : reqNxt;

    srcOk[IDX_RC]   = readySync[IDX_RC];
    srcOk[IDX_XOSC] = xoscEnNxt && readySync[IDX_XOSC];
    srcOk[IDX_PLL]  = pllEnNxt && readySync[IDX_PLL] && (!refNxt || xoscEnNxt);

    actNxt = actSel;
    if (failEvt && xoscInUse) begin
      actNxt = SRC_RC;
    end else if (target != actSel) begin
      case (target)
        SRC_XOSC: if (srcOk[IDX_XOSC]) actNxt = SRC_XOSC;
        SRC_PLL:  if (srcOk[IDX_PLL])  actNxt = SRC_PLL;
        default:  if (srcOk[IDX_RC])   actNxt = SRC_RC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSel    <= SRC_RC;
      reqSel    <= SRC_RC;
      xoscEn    <= 1'b0;
      pllEn     <= 1'b0;
      guardEn   <= 1'b0;
      guardFlag <= 1'b0;
      pllRef    <= 1'b0;
      pllMul    <= '0;
    end else begin
      actSel    <= actNxt;
      reqSel    <= reqNxt;
      xoscEn    <= xoscEnNxt;
      pllEn     <= pllEnNxt;
      guardEn   <= guardNxt;
      guardFlag <= flagNxt;
      pllRef    <= refNxt;
      pllMul    <= mulNxt;
    end
  end

  always_comb begin
    ctrlWord          = '0;
    ctrlWord[CB_XOSC] = xoscEn;
    ctrlWord[CB_PLL]  = pllEn;
    ctrlWord[CB_GRD]  = guardEn;

    cfgWord                 = '0;
    cfgWord[1:0]            = reqSel;
    cfgWord[FB_REF]         = pllRef;
    cfgWord[FB_MUL +: MUL_W] = pllMul;

    statWord                   = '0;
    statWord[1:0]              = actSel;
    statWord[SB_RDY +: N_SRC]  = readySync;
    statWord[SB_FLAG]          = guardFlag;
  end

endmodule

// File: rtl/sysclk_sel_ctrl.sv
module sysclk_sel_ctrl
  import sysclk_sel_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 16,
  parameter int MUL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rcReady,
  input  logic              xoscReady,
  input  logic              pllReady,
  input  logic              xoscFail,
  output logic              selRc,
  output logic              selXosc,
  output logic              selPll,
  output logic              xoscEnOut,
  output logic              pllEnOut,
  output logic              pllRefOut,
  output logic [MUL_W-1:0]  pllMulOut,
  output logic              guardIrq
);

  busStrobe_t        strobe;
  logic [N_SRC-1:0]  readyRaw, readySync;
  logic [DATA_W-1:0] ctrlWord, cfgWord, statWord;
  srcSel_e           actSel;

  assign readyRaw[IDX_RC]   = rcReady;
  assign readyRaw[IDX_XOSC] = xoscReady;
  assign readyRaw[IDX_PLL]  = pllReady;

  sysclk_sel_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .din(readyRaw), .dout(readySync)
  );

  sysclk_sel_busdec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_i (
    .busWr(busWr), .busAddr(busAddr), .ctrlWord(ctrlWord), .cfgWord(cfgWord),
    .statWord(statWord), .strobe(strobe), .busRdata(busRdata)
  );

  sysclk_sel_core #(.DATA_W(DATA_W), .MUL_W(MUL_W)) core_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .readySync(readySync), .xoscFail(xoscFail), .actSel(actSel),
    .xoscEn(xoscEnOut), .pllEn(pllEnOut), .pllRef(pllRefOut), .pllMul(pllMulOut),
    .guardFlag(guardIrq), .ctrlWord(ctrlWord), .cfgWord(cfgWord), .statWord(statWord)
  );

  assign selRc   = (actSel == SRC_RC);
  assign selXosc = (actSel == SRC_XOSC);
  assign selPll  = (actSel == SRC_PLL);

endmodule

// File: rtl/sysclk_sel_ctrl_chk.sv
module sysclk_sel_ctrl_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int MUL_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              xoscFail,
  input logic              selRc,
  input logic              selXosc,
  input logic              selPll,
  input logic              xoscEnOut,
  input logic              pllEnOut,
  input logic              pllRefOut,
  input logic [MUL_W-1:0]  pllMulOut,
  input logic              guardIrq
);

  logic clrWrite;
  assign clrWrite = busWr && (busAddr == '0) && busWdata[3];

  a_r5_onehot_select: assert property (@(posedge clk) disable iff (!rstN)
    $countones({selRc, selXosc, selPll}) == 1);

  a_r6_flag_from_fail: assert property (@(posedge clk) disable iff (!rstN)
    $rose(guardIrq) |-> $past(xoscFail));

  a_r6_xosc_off_on_fail: assert property (@(posedge clk) disable iff (!rstN)
    $rose(guardIrq) |-> !xoscEnOut);

  a_r6_leave_xosc: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(guardIrq) && $past(selXosc)) |-> selRc);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (guardIrq && !clrWrite) |=> guardIrq);

  a_r9_keep_xosc: assert property (@(posedge clk) disable iff (!rstN)
    (selXosc && !xoscFail) |=> xoscEnOut);

  a_r9_keep_pll_ref: assert property (@(posedge clk) disable iff (!rstN)
    (selPll && pllRefOut && !xoscFail) |=> xoscEnOut);

  a_r9_keep_pll: assert property (@(posedge clk) disable iff (!rstN)
    selPll |=> pllEnOut);

  a_r10_pll_cfg_locked: assert property (@(posedge clk) disable iff (!rstN)
    pllEnOut |=> ($stable(pllMulOut) && $stable(pllRefOut)));

  a_r3_pll_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selPll) |-> pllEnOut);

endmodule

bind sysclk_sel_ctrl sysclk_sel_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MUL_W(MUL_W)
) chk_i (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
  .xoscFail(xoscFail), .selRc(selRc), .selXosc(selXosc), .selPll(selPll),
  .xoscEnOut(xoscEnOut), .pllEnOut(pllEnOut), .pllRefOut(pllRefOut),
  .pllMulOut(pllMulOut), .guardIrq(guardIrq)
);

// File: tb/sysclk_sel_ctrl_tb.sv
module sysclk_sel_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 16;
  localparam int MUL_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic              rcReady = 1'b1;
  logic              xoscReady = 1'b0;
  logic              pllReady = 1'b0;
  logic              xoscFail = 1'b0;
  logic              selRc, selXosc, selPll;
  logic              xoscEnOut, pllEnOut, pllRefOut, guardIrq;
  logic [MUL_W-1:0]  pllMulOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysclk_sel_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MUL_W(MUL_W)) dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .rcReady(rcReady), .xoscReady(xoscReady), .pllReady(pllReady),
    .xoscFail(xoscFail), .selRc(selRc), .selXosc(selXosc), .selPll(selPll),
    .xoscEnOut(xoscEnOut), .pllEnOut(pllEnOut), .pllRefOut(pllRefOut),
    .pllMulOut(pllMulOut), .guardIrq(guardIrq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [DATA_W-1:0] data);
    busWr = 1'b1; busAddr = ADDR_W'(addr); busWdata = data;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [DATA_W-1:0] data);
    busAddr = ADDR_W'(addr);
    #1;
    data = busRdata;
  endtask

  task automatic failPulse();
    xoscFail = 1'b1;
    @(negedge clk);
    xoscFail = 1'b0;
  endtask

  task automatic checkAct(input string req, input logic [1:0] exp);
    logic [DATA_W-1:0] s;
    rd(2, s);
    chk(req, "active source", 32'(s[1:0]), 32'(exp));
    chk(req, "select lines", 32'({selPll, selXosc, selRc}),
        32'((exp == 2'b01) ? 3'b010 : (exp == 2'b10) ? 3'b100 : 3'b001));
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] v;
    checkAct("R1", 2'b00);
    rd(0, v); chk("R1", "control", 32'(v), 32'h0);
    rd(1, v); chk("R1", "config", 32'(v), 32'h0);
    chk("R1", "irq", 32'(guardIrq), 32'h0);
    chk("R5", "selRc after reset", 32'(selRc), 32'h1);
  endtask

  task automatic t_pending();
    logic [DATA_W-1:0] v;
    wr(0, 16'h0001);
    wr(1, 16'h0001);
    rd(1, v); chk("R2", "request field", 32'(v[1:0]), 32'h1);
    checkAct("R2", 2'b00);
    xoscReady = 1'b1;
    @(negedge clk); @(negedge clk);
    checkAct("R3", 2'b00);
    @(negedge clk);
    checkAct("R3", 2'b01);
  endtask

  task automatic t_keepActive();
    logic [DATA_W-1:0] v;
    wr(0, 16'h0000);
    rd(0, v); chk("R9", "xosc enable kept", 32'(v[0]), 32'h1);
    checkAct("R9", 2'b01);
  endtask

  task automatic t_pll();
    logic [DATA_W-1:0] v;
    wr(1, 16'h0511);
    rd(1, v); chk("R10", "config while pll off", 32'(v), 32'h0511);
    wr(0, 16'h0003);
    pllReady = 1'b1;
    repeat (3) @(negedge clk);
    checkAct("R3", 2'b01);
    wr(1, 16'h0902);
    checkAct("R3", 2'b10);
    rd(1, v); chk("R10", "config while pll on", 32'(v), 32'h0512);
    wr(0, 16'h0000);
    rd(0, v); chk("R9", "pll and its reference kept", 32'(v), 32'h0003);
  endtask

  task automatic t_reserved();
    logic [DATA_W-1:0] v;
    wr(1, 16'h0513);
    checkAct("R4", 2'b00);
    rd(1, v); chk("R4", "reserved code readback", 32'(v[1:0]), 32'h3);
    wr(0, 16'h0001);
    rd(0, v); chk("R9", "idle pll disable accepted", 32'(v), 32'h0001);
    wr(0, 16'h0003);
    wr(1, 16'h0512);
    checkAct("R4", 2'b10);
  endtask

  task automatic t_guardOffAndPll();
    logic [DATA_W-1:0] v;
    failPulse();
    checkAct("R12", 2'b10);
    rd(0, v); chk("R12", "enables unchanged", 32'(v), 32'h0003);
    chk("R12", "irq", 32'(guardIrq), 32'h0);
    wr(0, 16'h0007);
    failPulse();
    checkAct("R7", 2'b00);
    chk("R7", "irq", 32'(guardIrq), 32'h1);
    rd(0, v); chk("R7", "xosc disabled", 32'(v), 32'h0006);
    rd(1, v); chk("R7", "request forced internal", 32'(v[1:0]), 32'h0);
    repeat (4) @(negedge clk);
    chk("R8", "flag held", 32'(guardIrq), 32'h1);
    wr(0, 16'h0006);
    chk("R8", "flag held after plain write", 32'(guardIrq), 32'h1);
    wr(0, 16'h000E);
    chk("R8", "flag cleared", 32'(guardIrq), 32'h0);
    rd(2, v); chk("R8", "status flag", 32'(v[8]), 32'h0);
  endtask

  task automatic t_directFail();
    logic [DATA_W-1:0] v;
    wr(0, 16'h0005);
    wr(1, 16'h0001);
    checkAct("R6", 2'b01);
    failPulse();
    checkAct("R6", 2'b00);
    chk("R6", "irq", 32'(guardIrq), 32'h1);
    rd(0, v); chk("R6", "xosc disabled", 32'(v), 32'h0004);
    wr(0, 16'h000C);
    chk("R8", "flag cleared", 32'(guardIrq), 32'h0);
  endtask

  task automatic t_priority();
    logic [DATA_W-1:0] v;
    wr(0, 16'h0005);
    checkAct("R11", 2'b00);
    busWr = 1'b1; busAddr = 2'd1; busWdata = 16'h0001; xoscFail = 1'b1;
    @(negedge clk);
    busWr = 1'b0; xoscFail = 1'b0;
    checkAct("R11", 2'b00);
    rd(1, v); chk("R11", "request field", 32'(v[1:0]), 32'h0);
    chk("R11", "irq", 32'(guardIrq), 32'h1);
    repeat (2) @(negedge clk);
    checkAct("R11", 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pending();
    t_keepActive();
    t_pll();
    t_reserved();
    t_guardOffAndPll();
    t_directFail();
    t_priority();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule